// File: doc/BRIEF.md
# Prescaled Countdown Timer

This block is a 32-bit down-counter for a local interrupt unit. A core tick strobe goes through a power-of-two prescaler, and each prescaled step lowers the current count by one. Software programs the block over a 32-bit register port with four word registers: a start value, the live count, a divide code and a vector entry. Bit 17 of the vector entry selects whether the timer re-arms itself after it expires.

When the count steps from one to zero, the block drives a single-cycle event to the interrupt dispatcher. Vector lookup and masking are done in the dispatcher, not here.

- In single-shot mode the count stays at zero after the event.
- In repeating mode the count is refilled from the start value.

The timer does not count in three cases: the start value is zero, a single-shot count has run out, or the divide code is not a legal one.

All pins are plain control and register pins. The block has no streaming interface, so no back-pressure applies.

Top module: `cdt_timer_top`

## Requirements
- R1: After reset, all four registers read as zero and `timer_event` is low. Word addresses are: 0 start value, 1 live count, 2 divide code (4 bits, zero-extended), 3 vector entry. Divide code 0 selects divide-by-2.
- R2: A write to the start value register also places that value in the live count on the same edge, and clears the prescaler.
- R3: A write to the live count changes only the live count. The start value is kept.
- R4: The divide code is decoded from bits {3,1,0}: 111 gives /1, 000 gives /2, 001 gives /4, 010 gives /8, 011 gives /16, 100 gives /32, 101 gives /64, 110 gives /128. A step happens on every N-th tick after the prescaler was last cleared.
- R5: A divide code with bit 2 set is illegal. While it is held, the count does not change and no event is raised. The code still reads back as written.
- R6: While the start value is zero, the count does not change and no event is raised, even in repeating mode.
- R7: A step taken at count 1 raises `timer_event` for exactly one cycle, starting the cycle after that step. In single-shot mode the count then stays at zero with no further events.
- R8: In repeating mode, a step taken at count 1 raises the event and loads the start value into the count.
- R9: A register write to the start value or the live count on the same edge as a step wins over the step. No event is raised on that edge.
- R10: Vector entry bit 17 selects the mode: 0 is single-shot, 1 is repeating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_tick | input | 1 | One-cycle tick strobe fed to the prescaler |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Word address of the write |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 2 | Word address of the read |
| reg_rd_data | output | 32 | Read data, combinational from the read address |
| timer_event | output | 1 | Single-cycle expiry pulse to the dispatcher |

## Verification
The assertions assume that `core_tick` and `reg_wr_en` are single-cycle strobes sampled at the rising edge. They also assume that a halting condition (zero start value, illegal divide code, single-shot at zero) is judged on the values that register writes have already committed.

The stimulus drives every input on the falling edge, so each strobe is seen at exactly one rising edge. A write and a tick share an edge only in the collision case that R9 covers. Mode and divide code are always set before the start value is written, so every count starts with a freshly cleared prescaler.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned SHIFT_W = 3;
  localparam int unsigned ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_START = 2'd0,
    SEL_LIVE  = 2'd1,
    SEL_DIV   = 2'd2,
    SEL_VEC   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic               legal;
    logic [SHIFT_W-1:0] shift;
  } div_dec_t;

  // Bits {3,1,0} plus one (mod 8) give the shift; bit 2 marks an illegal code.
  function automatic div_dec_t decode_div(input logic [CODE_W-1:0] code);
    div_dec_t d;
    d.legal = ~code[2];
    d.shift = {code[3], code[1], code[0]} + 3'd1;
    return d;
  endfunction
endpackage

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W   = WORD_W,
  parameter int unsigned DIV_W    = CODE_W,
  parameter int unsigned MODE_POS = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] live_cnt,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] start_q,
  output logic [DIV_W-1:0]  div_q,
  output logic              periodic,
  output logic              start_wr,
  output logic              live_wr
);
  logic [DATA_W-1:0] vec_q;

  assign start_wr = wr_en && (wr_addr == SEL_START);
  assign live_wr  = wr_en && (wr_addr == SEL_LIVE);
  assign periodic = vec_q[MODE_POS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      div_q   <= '0;
      vec_q   <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        SEL_START: start_q <= wr_data;
        SEL_DIV:   div_q   <= wr_data[DIV_W-1:0];
        SEL_VEC:   vec_q   <= wr_data;
        default:   ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr)
      SEL_START: rd_data = start_q;
      SEL_LIVE:  rd_data = live_cnt;
      SEL_DIV:   rd_data = {{(DATA_W-DIV_W){1'b0}}, div_q};
      default:   rd_data = vec_q;
    endcase
  end

  // R2 / R3: the start value tracks its own writes only
  p_start_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |=> start_q == $past(wr_data));
  p_start_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_wr |=> $stable(start_q));
endmodule

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
#(
  parameter int unsigned SH_W  = SHIFT_W,
  localparam int unsigned PRE_W = (1 << SH_W) - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clear,
  input  logic [SH_W-1:0] shift,
  output logic            step
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   one_hot;
  logic [PRE_W-1:0] mask;

  always_comb begin
    one_hot = {{PRE_W{1'b0}}, 1'b1} << shift;
    mask    = one_hot[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
  end

  assign step = tick && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pre_q <= '0;
    else if (clear) pre_q <= '0;
    else if (tick)  pre_q <= pre_q + 1'b1;
  end

  // R2: a start write leaves the prescaler empty
  p_pre_cleared_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> pre_q == '0);
  // R4: without a tick the prescaler holds
  p_pre_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !clear |=> $stable(pre_q));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
  import cdt_pkg::*;
#(
  parameter int unsigned CNT_W = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             div_legal,
  input  logic             periodic,
  input  logic [CNT_W-1:0] start_val,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic running;
  assign running = (start_val != '0) && div_legal && (periodic || cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      expire_q <= 1'b0;
    end else begin
      expire_q <= 1'b0;
      if (load_en) begin
        cnt_q <= load_val;
      end else if (step && running) begin
        if (cnt_q == ONE) begin
          expire_q <= 1'b1;
          cnt_q    <= periodic ? start_val : '0;
        end else if (cnt_q == '0) begin
          cnt_q <= start_val;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  p_expire_from_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |-> $past(cnt_q) == ONE);
  p_oneshot_rests_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !periodic && cnt_q == '0 && !load_en |=> cnt_q == '0 && !expire_q);
  p_zero_start_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_val == '0 && !load_en |=> $stable(cnt_q) && !expire_q);
  p_bad_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_legal && !load_en |=> $stable(cnt_q) && !expire_q);
  p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> cnt_q == $past(load_val) && !expire_q);
  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q && $past(periodic) |-> cnt_q == $past(start_val));
endmodule

// File: rtl/cdt_timer_top.sv
module cdt_timer_top
  import cdt_pkg::*;
#(
  parameter int unsigned DATA_W   = WORD_W,
  parameter int unsigned MODE_POS = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_tick,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  output logic              timer_event
);
  logic [DATA_W-1:0] start_q;
  logic [DATA_W-1:0] live_q;
  logic [CODE_W-1:0] div_q;
  logic              periodic;
  logic              start_wr;
  logic              live_wr;
  logic              step;
  div_dec_t          dec;

  assign dec = decode_div(div_q);

  cdt_regs #(.DATA_W(DATA_W), .DIV_W(CODE_W), .MODE_POS(MODE_POS)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_addr  (reg_wr_addr),
    .wr_data  (reg_wr_data),
    .rd_addr  (reg_rd_addr),
    .live_cnt (live_q),
    .rd_data  (reg_rd_data),
    .start_q  (start_q),
    .div_q    (div_q),
    .periodic (periodic),
    .start_wr (start_wr),
    .live_wr  (live_wr)
  );

  cdt_prescale #(.SH_W(SHIFT_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (core_tick),
    .clear (start_wr),
    .shift (dec.shift),
    .step  (step)
  );

  cdt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .div_legal (dec.legal),
    .periodic  (periodic),
    .start_val (start_q),
    .load_en   (start_wr || live_wr),
    .load_val  (reg_wr_data),
    .cnt_q     (live_q),
    .expire_q  (timer_event)
  );
endmodule

// File: tb/cdt_timer_top_tb.sv
module cdt_timer_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        core_tick = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_wr_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        timer_event;

  int n_chk = 0;
  int n_bad = 0;
  int evt_cnt = 0;

  localparam logic [1:0] A_START = 2'd0, A_LIVE = 2'd1, A_DIV = 2'd2, A_VEC = 2'd3;
  localparam logic [31:0] REPEAT = 32'h0002_0000;

  always #2.5 clk = ~clk;

  cdt_timer_top u_dut (
    .clk(clk), .rst_n(rst_n), .core_tick(core_tick),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data), .timer_event(timer_event)
  );

  always @(negedge clk) if (rst_n && timer_event) evt_cnt++;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    #1;
  endtask

  task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
    reg_rd_addr = a;
    #1;
    check(req, reg_rd_data, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      core_tick = 1'b1;
    end
    @(negedge clk);
    core_tick = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rd_check("R1 start", A_START, 0);
    rd_check("R1 live", A_LIVE, 0);
    rd_check("R1 div", A_DIV, 0);
    rd_check("R1 vec", A_VEC, 0);
    check("R1 event", {31'd0, timer_event}, 0);
  endtask

  task automatic t_div2_oneshot();
    wr(A_DIV, 32'h0); wr(A_VEC, 32'h0); wr(A_START, 3);
    evt_cnt = 0;
    rd_check("R2 live loaded", A_LIVE, 3);
    ticks(2);
    rd_check("R4 div2 step", A_LIVE, 2);
    ticks(4);
    rd_check("R7 reached zero", A_LIVE, 0);
    check("R7 one event", evt_cnt, 1);
    ticks(10);
    rd_check("R7 stays zero", A_LIVE, 0);
    check("R7 no more events", evt_cnt, 1);
  endtask

  task automatic t_div_codes();
    wr(A_DIV, 32'hB); wr(A_START, 5);
    ticks(3);
    rd_check("R4 div1", A_LIVE, 2);
    wr(A_DIV, 32'h2); wr(A_START, 2);
    evt_cnt = 0;
    ticks(15);
    rd_check("R4 div8 partial", A_LIVE, 1);
    ticks(1);
    rd_check("R4 div8 done", A_LIVE, 0);
    check("R4 div8 event", evt_cnt, 1);
    wr(A_DIV, 32'hA); wr(A_START, 1);
    evt_cnt = 0;
    ticks(127);
    rd_check("R4 div128 partial", A_LIVE, 1);
    check("R4 div128 no event yet", evt_cnt, 0);
    ticks(1);
    check("R4 div128 event", evt_cnt, 1);
  endtask

  task automatic t_prescale_clear();
    wr(A_DIV, 32'h1); wr(A_START, 9);
    ticks(3);
    rd_check("R2 div4 partial", A_LIVE, 9);
    wr(A_START, 9);
    ticks(3);
    rd_check("R2 prescaler cleared", A_LIVE, 9);
    ticks(1);
    rd_check("R2 step after clear", A_LIVE, 8);
  endtask

  task automatic t_periodic();
    wr(A_VEC, REPEAT); wr(A_DIV, 32'hB); wr(A_START, 3);
    evt_cnt = 0;
    rd_check("R10 vec readback", A_VEC, REPEAT);
    ticks(9);
    check("R8 three events", evt_cnt, 3);
    rd_check("R8 reloaded", A_LIVE, 3);
    ticks(1);
    rd_check("R10 keeps counting", A_LIVE, 2);
  endtask

  task automatic t_bad_div();
    wr(A_VEC, 32'h0); wr(A_DIV, 32'h4); wr(A_START, 4);
    evt_cnt = 0;
    ticks(10);
    rd_check("R5 held", A_LIVE, 4);
    check("R5 no event", evt_cnt, 0);
    rd_check("R5 code readback", A_DIV, 4);
    wr(A_DIV, 32'hB);
    ticks(1);
    rd_check("R5 resumes", A_LIVE, 3);
  endtask

  task automatic t_zero_start();
    wr(A_VEC, REPEAT); wr(A_DIV, 32'hB); wr(A_START, 0);
    evt_cnt = 0;
    ticks(5);
    rd_check("R6 zero held", A_LIVE, 0);
    wr(A_LIVE, 5);
    ticks(5);
    rd_check("R6 live held", A_LIVE, 5);
    check("R6 no event", evt_cnt, 0);
  endtask

  task automatic t_live_write();
    wr(A_VEC, 32'h0); wr(A_DIV, 32'hB); wr(A_START, 10);
    wr(A_LIVE, 2);
    rd_check("R3 start kept", A_START, 10);
    rd_check("R3 live written", A_LIVE, 2);
    evt_cnt = 0;
    ticks(2);
    rd_check("R3 expired from written", A_LIVE, 0);
    check("R3 event", evt_cnt, 1);
  endtask

  task automatic t_collide();
    wr(A_START, 10);
    evt_cnt = 0;
    @(negedge clk);
    core_tick = 1'b1; reg_wr_en = 1'b1; reg_wr_addr = A_LIVE; reg_wr_data = 7;
    @(negedge clk);
    core_tick = 1'b0; reg_wr_en = 1'b0;
    #1;
    rd_check("R9 live write wins", A_LIVE, 7);
    @(negedge clk);
    core_tick = 1'b1; reg_wr_en = 1'b1; reg_wr_addr = A_START; reg_wr_data = 1;
    @(negedge clk);
    core_tick = 1'b0; reg_wr_en = 1'b0;
    #1;
    rd_check("R9 start write wins", A_LIVE, 1);
    check("R9 no event", evt_cnt, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_div2_oneshot();
    t_div_codes();
    t_prescale_clear();
    t_periodic();
    t_bad_div();
    t_zero_start();
    t_live_write();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule